// File: doc/BRIEF.md
# Local Block Store with Transfer Queue

This block holds the data blocks that a memory module keeps on its own side of a distributed oblivious tree. Its storage has two parts. A main store of fixed-size slots holds blocks that take part in local accesses: blocks fetched from a local path are inserted there. A small first-in first-out transfer queue holds real blocks that other modules send in. Dummy blocks that arrive are thrown away.

Queued blocks leave the queue in one of two ways. When a block in the main store is reassigned to a different module and leaves, the head of the queue takes its slot in the same cycle, so the main store's occupancy does not change. At any access opportunity that does not swap, a pseudo-random draw compared against a programmable threshold may start an extra local access. That access takes the head block out of the queue and hands it to the path logic for write-back into the tree. The block also raises a drain request when the main store nears capacity, flags queue fill levels, and records a sticky overflow when a block arrives at a full queue.

Top module: `xfer_stash`

## Requirements
- R1: After reset the main store and the queue are empty: `stash_count`=0, `q_count`=0, `q_empty`=1, `q_full`=0, `q_high`=0, `q_ovf`=0, `xacc_req`=0 and `drain_req`=0.
- R2: An insert writes the block into the lowest-numbered free slot, and the slot reads back through `rd_idx` on the next cycle. An insert while all `STASH_ENTRIES` slots are valid is ignored.
- R3: An append with `app_dummy`=1 is dropped and leaves `q_count` unchanged. A real append goes to the tail of the queue, and queued blocks leave in arrival order.
- R4: A leave on a valid slot while the queue holds blocks puts the queue head into that slot. `stash_count` stays the same and `q_count` drops by one. A leave on a valid slot while the queue is empty frees the slot.
- R5: A remove on a valid slot frees it and does not touch the queue. A remove or leave naming an invalid slot has no effect.
- R6: An access opportunity with a non-empty queue and no swap in that cycle fires when the random value is at most `p_thresh`. On the next cycle `xacc_req` is high for one cycle with the head block on the `xacc_*` outputs, and the queue has popped it. A threshold of 0 never fires and an all-ones threshold always fires.
- R7: `q_empty` is high when `q_count`=0, `q_full` is high when `q_count`=`Q_DEPTH`, and `q_high` is high when `q_count`>=`Q_HIGH`.
- R8: A real append while the queue is full is dropped and sets `q_ovf`, which stays high until reset.
- R9: `drain_req` is high exactly when `stash_count`>=`DRAIN_MARK`.
- R10: When a swap and an access opportunity fall in the same cycle, only the swap takes a block from the queue and no extra access fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| app_valid | input | 1 | Block arriving from another module |
| app_dummy | input | 1 | Arriving block is a dummy |
| app_addr | input | ADDR_W | Arriving block address |
| app_leaf | input | LEAF_W | Arriving block leaf |
| app_data | input | DATA_W | Arriving block payload |
| ins_valid | input | 1 | Insert a block fetched from a local path |
| ins_addr | input | ADDR_W | Inserted block address |
| ins_leaf | input | LEAF_W | Inserted block leaf |
| ins_data | input | DATA_W | Inserted block payload |
| rm_valid | input | 1 | Remove a slot (evicted locally) |
| rm_idx | input | SIW | Slot to remove |
| leave_valid | input | 1 | Slot's block departs to another module |
| leave_idx | input | SIW | Departing slot |
| access_opp | input | 1 | Access opportunity strobe |
| p_thresh | input | RND_W | Extra-access probability threshold |
| rd_idx | input | SIW | Slot to observe |
| rd_valid | output | 1 | Observed slot holds a block |
| rd_addr | output | ADDR_W | Observed block address |
| rd_leaf | output | LEAF_W | Observed block leaf |
| rd_data | output | DATA_W | Observed block payload |
| xacc_req | output | 1 | Extra local access request pulse |
| xacc_addr | output | ADDR_W | Block for the extra access: address |
| xacc_leaf | output | LEAF_W | Block for the extra access: leaf |
| xacc_data | output | DATA_W | Block for the extra access: payload |
| drain_req | output | 1 | Main store near overflow |
| stash_count | output | SCW | Valid slots in the main store |
| q_count | output | QCW | Blocks in the transfer queue |
| q_full | output | 1 | Queue full |
| q_empty | output | 1 | Queue empty |
| q_high | output | 1 | Queue at or above high-water mark |
| q_ovf | output | 1 | Sticky queue overflow |

## Verification
The assertions assume that insert, remove and leave are each issued at most once per cycle. They also assume that the path logic never names the same slot for both remove and leave when it means both, and that `access_opp`, the thresholds and all indices are held at known values throughout reset. The stimulus changes inputs only between clock edges, drives every strobe low whenever it is idle, and uses only the two threshold extremes whose outcome does not depend on the generator's sequence. Blocks taken by extra accesses are predicted in the order they were appended and are compared as they emerge.

// File: rtl/xfer_stash_pkg.sv
package xfer_stash_pkg;

  // One right-shift Galois step; taps given in the same right-shift form.
  function automatic logic [31:0] galois_step(input logic [31:0] s, input logic [31:0] taps);
    return s[0] ? ((s >> 1) ^ taps) : (s >> 1);
  endfunction

  // Extra access is taken when the draw does not exceed the threshold.
  function automatic logic chance_hit(input logic [31:0] rnd, input logic [31:0] thr);
    return rnd <= thr;
  endfunction

  // Saturating-free next pointer for a ring of arbitrary depth.
  function automatic logic [31:0] ring_next(input logic [31:0] p, input logic [31:0] depth);
    return (p == depth - 1) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/xfer_stash_rng.sv
module xfer_stash_rng #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] rnd
);
  import xfer_stash_pkg::*;

  logic [W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SEED;
    else        st <= W'(galois_step(32'(st), 32'(TAPS)));
  end

  assign rnd = st;
endmodule

// File: rtl/xfer_stash_xq.sv
module xfer_stash_xq #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32,
  parameter int unsigned HIGH  = 6,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_blk,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          high,
  output logic          ovf
);
  import xfer_stash_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          acc, pop_ok;

  assign full   = (32'(count) == DEPTH);
  assign empty  = (count == '0);
  assign high   = (32'(count) >= HIGH);
  assign acc    = push && !full;
  assign pop_ok = pop && !empty;
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (acc) mem[wr_ptr] <= push_blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (acc)    wr_ptr <= PW'(ring_next(32'(wr_ptr), DEPTH));
      if (pop_ok) rd_ptr <= PW'(ring_next(32'(rd_ptr), DEPTH));
      unique case ({acc, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/xfer_stash_slots.sv
module xfer_stash_slots #(
  parameter int unsigned ENTRIES = 200,
  parameter int unsigned W       = 32,
  localparam int unsigned IW     = $clog2(ENTRIES),
  localparam int unsigned SPAN   = 1 << IW,
  localparam int unsigned CW     = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          leave_valid,
  input  logic [IW-1:0] leave_idx,
  input  logic          swap_avail,
  input  logic [W-1:0]  swap_blk,
  input  logic          rm_valid,
  input  logic [IW-1:0] rm_idx,
  input  logic          ins_valid,
  input  logic [W-1:0]  ins_blk,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [W-1:0]  rd_blk,
  output logic [CW-1:0] count,
  output logic          swap_taken,
  output logic          rm_hit,
  output logic          ins_ok
);
  logic [ENTRIES-1:0] vld;
  logic [SPAN-1:0]    vld_ext;
  logic [W-1:0]       slot_blk [ENTRIES];
  logic               leave_hit;
  logic               free_found;
  logic [IW-1:0]      free_idx;

  assign vld_ext = SPAN'(vld);

  // Lowest-numbered free slot.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end

  assign leave_hit  = leave_valid && vld_ext[leave_idx];
  assign rm_hit     = rm_valid && vld_ext[rm_idx] && !(leave_hit && (rm_idx == leave_idx));
  assign swap_taken = leave_hit && swap_avail;
  assign ins_ok     = ins_valid && free_found;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    localparam logic [IW-1:0] ME = IW'(g);
    logic         v;
    logic [W-1:0] b;
    logic         hit_leave, hit_rm, hit_ins;

    assign hit_leave = leave_hit && (leave_idx == ME);
    assign hit_rm    = rm_hit && (rm_idx == ME);
    assign hit_ins   = ins_ok && (free_idx == ME);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         v <= 1'b0;
      else if (hit_leave) v <= swap_avail;
      else if (hit_rm)    v <= 1'b0;
      else if (hit_ins)   v <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit_leave && swap_avail) b <= swap_blk;
      else if (hit_ins)            b <= ins_blk;
    end

    assign vld[g]      = v;
    assign slot_blk[g] = b;
  end

  // Occupancy tracked as a running count of admitted and released blocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else count <= count + CW'(ins_ok) - CW'(rm_hit) - CW'(leave_hit && !swap_avail);
  end

  always_comb begin
    rd_blk = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (IW'(i) == rd_idx) rd_blk = slot_blk[i];
    end
  end
  assign rd_valid = vld_ext[rd_idx];
endmodule

// File: rtl/xfer_stash.sv
module xfer_stash #(
  parameter int unsigned STASH_ENTRIES = 200,
  parameter int unsigned DRAIN_MARK    = 196,
  parameter int unsigned Q_DEPTH       = 8,
  parameter int unsigned Q_HIGH        = 6,
  parameter int unsigned ADDR_W        = 24,
  parameter int unsigned LEAF_W        = 16,
  parameter int unsigned DATA_W        = 64,
  parameter int unsigned RND_W         = 8,
  parameter logic [RND_W-1:0] RND_TAPS = 8'hB8,
  parameter logic [RND_W-1:0] RND_SEED = 8'h5A,
  localparam int unsigned BLK_W = ADDR_W + LEAF_W + DATA_W,
  localparam int unsigned SIW   = $clog2(STASH_ENTRIES),
  localparam int unsigned SCW   = $clog2(STASH_ENTRIES + 1),
  localparam int unsigned QCW   = $clog2(Q_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_valid,
  input  logic              app_dummy,
  input  logic [ADDR_W-1:0] app_addr,
  input  logic [LEAF_W-1:0] app_leaf,
  input  logic [DATA_W-1:0] app_data,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [LEAF_W-1:0] ins_leaf,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              rm_valid,
  input  logic [SIW-1:0]    rm_idx,
  input  logic              leave_valid,
  input  logic [SIW-1:0]    leave_idx,
  input  logic              access_opp,
  input  logic [RND_W-1:0]  p_thresh,
  input  logic [SIW-1:0]    rd_idx,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEAF_W-1:0] rd_leaf,
  output logic [DATA_W-1:0] rd_data,
  output logic              xacc_req,
  output logic [ADDR_W-1:0] xacc_addr,
  output logic [LEAF_W-1:0] xacc_leaf,
  output logic [DATA_W-1:0] xacc_data,
  output logic              drain_req,
  output logic [SCW-1:0]    stash_count,
  output logic [QCW-1:0]    q_count,
  output logic              q_full,
  output logic              q_empty,
  output logic              q_high,
  output logic              q_ovf
);
  import xfer_stash_pkg::*;

  logic [BLK_W-1:0] q_head, rd_blk, xacc_blk;
  logic [RND_W-1:0] rnd;
  logic             q_push, q_pop, swap_taken, rm_hit, ins_ok, xacc_fire;

  assign q_push    = app_valid && !app_dummy;
  assign xacc_fire = access_opp && !q_empty && !swap_taken &&
                     chance_hit(32'(rnd), 32'(p_thresh));
  assign q_pop     = swap_taken || xacc_fire;

  xfer_stash_rng #(.W(RND_W), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_rng (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  xfer_stash_xq #(.DEPTH(Q_DEPTH), .W(BLK_W), .HIGH(Q_HIGH)) u_xq (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_blk({app_addr, app_leaf, app_data}),
    .pop(q_pop), .head(q_head), .count(q_count),
    .full(q_full), .empty(q_empty), .high(q_high), .ovf(q_ovf)
  );

  xfer_stash_slots #(.ENTRIES(STASH_ENTRIES), .W(BLK_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .leave_valid(leave_valid), .leave_idx(leave_idx),
    .swap_avail(!q_empty), .swap_blk(q_head),
    .rm_valid(rm_valid), .rm_idx(rm_idx),
    .ins_valid(ins_valid), .ins_blk({ins_addr, ins_leaf, ins_data}),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_blk(rd_blk),
    .count(stash_count), .swap_taken(swap_taken),
    .rm_hit(rm_hit), .ins_ok(ins_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xacc_req <= 1'b0;
    else        xacc_req <= xacc_fire;
  end

  always_ff @(posedge clk) begin
    if (xacc_fire) xacc_blk <= q_head;
  end

  assign {rd_addr, rd_leaf, rd_data}       = rd_blk;
  assign {xacc_addr, xacc_leaf, xacc_data} = xacc_blk;
  assign drain_req = (32'(stash_count) >= DRAIN_MARK);
endmodule

// File: rtl/xfer_stash_chk.sv
module xfer_stash_chk #(
  parameter int unsigned Q_DEPTH = 8,
  parameter int unsigned RND_W   = 8,
  parameter int unsigned SCW     = 8,
  parameter int unsigned QCW     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             app_valid,
  input logic             app_dummy,
  input logic             access_opp,
  input logic [RND_W-1:0] p_thresh,
  input logic             swap_taken,
  input logic             rm_hit,
  input logic             ins_ok,
  input logic             q_pop,
  input logic             xacc_req,
  input logic [SCW-1:0]   stash_count,
  input logic [QCW-1:0]   q_count,
  input logic             q_full,
  input logic             q_empty,
  input logic             q_ovf
);
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(q_full && q_empty));

  // R7
  q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) 32'(q_count) <= Q_DEPTH);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) q_ovf |=> q_ovf);

  // R6
  xacc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) xacc_req |-> $past(access_opp));

  // R6
  zero_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_opp && (p_thresh == '0)) |=> !xacc_req);

  // R4
  swap_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_taken && !ins_ok && !rm_hit) |=> $stable(stash_count));

  // R10
  swap_blocks_xacc_chk: assert property (@(posedge clk) disable iff (!rst_n) swap_taken |=> !xacc_req);

  // R3
  dummy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (app_valid && app_dummy && !q_pop) |=> $stable(q_count));
endmodule

bind xfer_stash xfer_stash_chk #(
  .Q_DEPTH(Q_DEPTH), .RND_W(RND_W), .SCW(SCW), .QCW(QCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .app_valid(app_valid), .app_dummy(app_dummy),
  .access_opp(access_opp), .p_thresh(p_thresh), .swap_taken(swap_taken),
  .rm_hit(rm_hit), .ins_ok(ins_ok), .q_pop(q_pop), .xacc_req(xacc_req),
  .stash_count(stash_count), .q_count(q_count), .q_full(q_full),
  .q_empty(q_empty), .q_ovf(q_ovf)
);

// File: tb/xfer_stash_test.sv
module xfer_stash_test;
  localparam int S = 8, QD = 4, QH = 3, DM = 6;
  localparam int AW = 8, LW = 6, DW = 16, RW = 8;
  localparam int BW = AW + LW + DW;
  localparam int SIW = $clog2(S), SCW = $clog2(S + 1), QCW = $clog2(QD + 1);

  logic clk = 0, rst_n = 0;
  logic app_valid = 0, app_dummy = 0;
  logic [AW-1:0] app_addr = 0; logic [LW-1:0] app_leaf = 0; logic [DW-1:0] app_data = 0;
  logic ins_valid = 0;
  logic [AW-1:0] ins_addr = 0; logic [LW-1:0] ins_leaf = 0; logic [DW-1:0] ins_data = 0;
  logic rm_valid = 0, leave_valid = 0, access_opp = 0;
  logic [SIW-1:0] rm_idx = 0, leave_idx = 0, rd_idx = 0;
  logic [RW-1:0] p_thresh = 0;
  logic rd_valid, xacc_req, drain_req, q_full, q_empty, q_high, q_ovf;
  logic [AW-1:0] rd_addr, xacc_addr; logic [LW-1:0] rd_leaf, xacc_leaf;
  logic [DW-1:0] rd_data, xacc_data;
  logic [SCW-1:0] stash_count; logic [QCW-1:0] q_count;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [BW-1:0] exp_q [$];

  xfer_stash #(.STASH_ENTRIES(S), .DRAIN_MARK(DM), .Q_DEPTH(QD), .Q_HIGH(QH),
               .ADDR_W(AW), .LEAF_W(LW), .DATA_W(DW), .RND_W(RW)) uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] mk(input int n);
    return {AW'(n * 3 + 1), LW'(n + 5), DW'(16'hA000 + n)};
  endfunction

  task automatic cyc();
    @(posedge clk); #2;
    app_valid = 0; app_dummy = 0; ins_valid = 0; rm_valid = 0;
    leave_valid = 0; access_opp = 0;
  endtask

  task automatic insert(input logic [BW-1:0] b);
    {ins_addr, ins_leaf, ins_data} = b; ins_valid = 1; cyc();
  endtask

  task automatic append(input logic [BW-1:0] b, input logic dummy);
    {app_addr, app_leaf, app_data} = b; app_dummy = dummy; app_valid = 1; cyc();
  endtask

  task automatic look(input string req, input int idx, input logic v, input logic [BW-1:0] b);
    rd_idx = SIW'(idx); #1;
    chk(req, 64'(rd_valid), 64'(v));
    if (v) chk(req, 64'({rd_addr, rd_leaf, rd_data}), 64'(b));
  endtask

  // Scoreboard monitor for extra-access blocks (R6, R3 order).
  always @(negedge clk) begin
    if (rst_n && xacc_req) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6: actual unexpected xacc %0h expected none", {xacc_addr, xacc_leaf, xacc_data});
      end else begin
        logic [BW-1:0] e;
        e = exp_q.pop_front();
        if ({xacc_addr, xacc_leaf, xacc_data} !== e) begin
          fails++;
          $display("FAIL R6: actual %0h expected %0h", {xacc_addr, xacc_leaf, xacc_data}, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #20; @(posedge clk); #2; rst_n = 1; @(posedge clk); #2;
    // R1
    chk("R1 stash_count", 64'(stash_count), 0); chk("R1 q_count", 64'(q_count), 0);
    chk("R1 q_empty", 64'(q_empty), 1); chk("R1 q_full", 64'(q_full), 0);
    chk("R1 q_high", 64'(q_high), 0); chk("R1 q_ovf", 64'(q_ovf), 0);
    chk("R1 xacc_req", 64'(xacc_req), 0); chk("R1 drain_req", 64'(drain_req), 0);

    // R2: lowest free slots 0,1,2
    for (int i = 0; i < 3; i++) insert(mk(i));
    chk("R2 count", 64'(stash_count), 3);
    look("R2 slot1", 1, 1, mk(1));

    // R3: dummy dropped, real appends queued
    append(mk(50), 1);
    chk("R3 dummy q_count", 64'(q_count), 0);
    append(mk(10), 0); append(mk(11), 0);
    chk("R3 q_count", 64'(q_count), 2);

    // R4: leave with swap
    leave_idx = 1; leave_valid = 1; cyc();
    chk("R4 count", 64'(stash_count), 3); chk("R4 q_count", 64'(q_count), 1);
    look("R4 slot1", 1, 1, mk(10));

    // R5: leave of invalid slot ignored; remove frees without queue effect
    leave_idx = 5; leave_valid = 1; cyc();
    chk("R5 q_count", 64'(q_count), 1); chk("R5 count", 64'(stash_count), 3);
    rm_idx = 0; rm_valid = 1; cyc();
    chk("R5 rm count", 64'(stash_count), 2); chk("R5 rm q_count", 64'(q_count), 1);
    look("R5 slot0", 0, 0, '0);

    // R6: zero threshold never fires
    p_thresh = 0; access_opp = 1; cyc();
    chk("R6 zero xacc", 64'(xacc_req), 0); chk("R6 zero q_count", 64'(q_count), 1);

    // R10: swap and opportunity together
    p_thresh = '1; access_opp = 1; leave_idx = 2; leave_valid = 1; cyc();
    chk("R10 xacc", 64'(xacc_req), 0); chk("R10 q_count", 64'(q_count), 0);
    look("R10 slot2", 2, 1, mk(11));

    // R7, R8: fill queue
    for (int i = 0; i < 4; i++) begin
      append(mk(20 + i), 0);
      chk("R7 high", 64'(q_high), 64'(i + 1 >= QH));
      chk("R7 full", 64'(q_full), 64'(i + 1 == QD));
    end
    append(mk(30), 0);
    chk("R8 q_count", 64'(q_count), 4); chk("R8 ovf", 64'(q_ovf), 1);

    // R6: all-ones threshold drains queue in order via scoreboard
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back(mk(20 + i));
      p_thresh = '1; access_opp = 1; cyc();
      chk("R6 fire", 64'(xacc_req), 1);
    end
    @(negedge clk); #1;
    chk("R7 empty", 64'(q_empty), 1); chk("R8 sticky", 64'(q_ovf), 1);
    chk("R6 scoreboard drained", 64'(exp_q.size()), 0);
    @(posedge clk); #2;

    // R9, R2: fill main store
    for (int i = 0; i < 6; i++) begin
      insert(mk(40 + i));
      chk("R9 count", 64'(stash_count), 64'(3 + i));
      chk("R9 drain", 64'(drain_req), 64'(3 + i >= DM));
    end
    look("R2 slot0 refill", 0, 1, mk(40));
    insert(mk(60));
    chk("R2 full insert", 64'(stash_count), 8);
    look("R2 slot7", 7, 1, mk(45));

    // R4: leave with empty queue frees slot
    leave_idx = 3; leave_valid = 1; cyc();
    chk("R4 free count", 64'(stash_count), 7);
    look("R4 slot3", 3, 0, '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule